// File: doc/BRIEF.md
# Vector Byte-Lane Predicate Compare and Combine Unit

This block turns two wide data vectors into byte-lane predicates and merges them into one predicate. Each operand vector is first reduced to one predicate bit per byte lane. The reduction is either a signed byte greater-than test against the low byte of a broadcast scalar, or a 32-bit equality test against the full broadcast scalar. In the word form, each word's result fills all four bit positions of that word's bytes. The two operand predicates are then merged by AND, OR or XOR. The AND and OR forms can take the complement of the second operand.

The merged predicate is registered and drives a masked fill of the held result vector. Every byte lane whose predicate bit is set becomes 0xFF. Every other lane keeps the value it held before. A valid strobe travels with each result, one cycle behind the input strobe. This makes the block a drop-in stage for vector predicate generation and masked constant writes next to a vector register file, which stays outside the block.

Top module: `vpred_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `pred` is all zeros and `out_vec` is all zeros.
- R2: With `cmp_word` = 0, operand bit i is 1 exactly when byte i (bits 8i+7..8i) of that vector, read as a signed 8-bit value, is greater than `scalar[7:0]` read as signed.
- R3: With `cmp_word` = 1, operand bits 4k..4k+3 are all 1 exactly when word k (bits 32k+31..32k) of that vector equals `scalar`; otherwise all four are 0.
- R4: The `op` encoding is 0 = AND, 1 = OR, 2 = XOR of the predicate from `vec_a` with the predicate from `vec_b`.
- R5: With `inv_b` = 1 and `op` 0 or 1, the predicate from `vec_b` is complemented before it is combined.
- R6: With `op` = 2, `inv_b` has no effect on the result.
- R7: `op` = 3 is unsupported and gives an all-zero predicate, which leaves `out_vec` unchanged.
- R8: On each accepted input, byte i of `out_vec` becomes 0xFF where the new predicate bit i is 1. Every other byte keeps its previous value.
- R9: `pred` and `out_vec` update on the clock edge at which `in_valid` is 1. `out_valid` is 1 in exactly the cycle after each such edge. While `in_valid` is 0, `pred` and `out_vec` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input operands and controls are valid |
| vec_a | input | VEC_BYTES*8 | First operand vector |
| vec_b | input | VEC_BYTES*8 | Second operand vector |
| scalar | input | 32 | Broadcast compare value (low byte for byte mode) |
| cmp_word | input | 1 | 0 = signed byte greater-than, 1 = 32-bit equality |
| op | input | 2 | Combine operation: 0 AND, 1 OR, 2 XOR, 3 unsupported |
| inv_b | input | 1 | Complement second predicate for AND/OR |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| pred | output | VEC_BYTES | Registered combined predicate, one bit per byte |
| out_vec | output | VEC_BYTES*8 | Held vector after masked 0xFF fill |

## Verification
Some properties are checked on every cycle: the one-cycle valid latency, that the outputs hold while idle, and that every set predicate lane reads 0xFF while every clear lane keeps its old byte. They also check that word-mode predicates come in whole four-bit groups and that the unsupported opcode yields zero. The exact compare results are shown only by the bench's scenarios. These cover signed thresholds at the extremes −128 and 127, mixed-sign byte patterns, and word equality against zero. The scenarios also cover each combine form with and without the complement, and XOR ignoring the invert control.

// File: rtl/vpred_pkg.sv
package vpred_pkg;
   typedef enum logic [1:0] {
      OP_AND  = 2'd0,
      OP_OR   = 2'd1,
      OP_XOR  = 2'd2,
      OP_RSVD = 2'd3
   } vpred_op_e;
endpackage

// File: rtl/vpred_cmp.sv
module vpred_cmp #(
   parameter int VEC_BYTES = 128,
   localparam int VEC_W = VEC_BYTES * 8,
   localparam int WORDS = VEC_BYTES / 4
) (
   input  logic [VEC_W-1:0]     vec,
   input  logic [31:0]          scalar,
   input  logic                 word_mode,
   output logic [VEC_BYTES-1:0] lane_pred
);
   logic [VEC_BYTES-1:0] byte_gt;
   logic [VEC_BYTES-1:0] word_eq;

   for (genvar gi = 0; gi < VEC_BYTES; gi++) begin : g_byte
      assign byte_gt[gi] = $signed(vec[8*gi +: 8]) > $signed(scalar[7:0]);
   end

   for (genvar gw = 0; gw < WORDS; gw++) begin : g_word
      assign word_eq[4*gw +: 4] = {4{vec[32*gw +: 32] == scalar}};
   end

   assign lane_pred = word_mode ? word_eq : byte_gt;
endmodule

// File: rtl/vpred_logic.sv
module vpred_logic
   import vpred_pkg::*;
#(
   parameter int VEC_BYTES = 128
) (
   input  logic [VEC_BYTES-1:0] pa,
   input  logic [VEC_BYTES-1:0] pb,
   input  vpred_op_e            op,
   input  logic                 inv_b,
   output logic [VEC_BYTES-1:0] pq
);
   logic [VEC_BYTES-1:0] pb_sel;

   assign pb_sel = inv_b ? ~pb : pb;

   always_comb begin
      unique case (op)
         OP_AND:  pq = pa & pb_sel;
         OP_OR:   pq = pa | pb_sel;
         OP_XOR:  pq = pa ^ pb;
         default: pq = '0;
      endcase
   end
endmodule

// File: rtl/vpred_fill.sv
module vpred_fill #(
   parameter int VEC_BYTES = 128,
   parameter logic [7:0] FILL = 8'hFF,
   localparam int VEC_W = VEC_BYTES * 8
) (
   input  logic [VEC_BYTES-1:0] mask,
   input  logic [VEC_W-1:0]     cur,
   output logic [VEC_W-1:0]     nxt
);
   for (genvar gi = 0; gi < VEC_BYTES; gi++) begin : g_lane
      assign nxt[8*gi +: 8] = mask[gi] ? FILL : cur[8*gi +: 8];
   end
endmodule

// File: rtl/vpred_unit.sv
module vpred_unit
   import vpred_pkg::*;
#(
   parameter int VEC_BYTES = 128,
   localparam int VEC_W = VEC_BYTES * 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [VEC_W-1:0]     vec_a,
   input  logic [VEC_W-1:0]     vec_b,
   input  logic [31:0]          scalar,
   input  logic                 cmp_word,
   input  logic [1:0]           op,
   input  logic                 inv_b,
   output logic                 out_valid,
   output logic [VEC_BYTES-1:0] pred,
   output logic [VEC_W-1:0]     out_vec
);
   if (VEC_BYTES < 4 || (VEC_BYTES % 4) != 0) begin : g_bad_size
      $error("VEC_BYTES must be a positive multiple of 4");
   end

   logic [VEC_BYTES-1:0] pa, pb, pq;
   logic [VEC_W-1:0]     vec_nxt;

   vpred_cmp #(.VEC_BYTES(VEC_BYTES)) i_cmp_a (
      .vec(vec_a), .scalar(scalar), .word_mode(cmp_word), .lane_pred(pa));

   vpred_cmp #(.VEC_BYTES(VEC_BYTES)) i_cmp_b (
      .vec(vec_b), .scalar(scalar), .word_mode(cmp_word), .lane_pred(pb));

   vpred_logic #(.VEC_BYTES(VEC_BYTES)) i_logic (
      .pa(pa), .pb(pb), .op(vpred_op_e'(op)), .inv_b(inv_b), .pq(pq));

   vpred_fill #(.VEC_BYTES(VEC_BYTES)) i_fill (
      .mask(pq), .cur(out_vec), .nxt(vec_nxt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         pred      <= '0;
         out_vec   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            pred    <= pq;
            out_vec <= vec_nxt;
         end
      end
   end
endmodule

// File: rtl/vpred_unit_chk.sv
module vpred_unit_chk #(
   parameter int VEC_BYTES = 128,
   localparam int VEC_W = VEC_BYTES * 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 cmp_word,
   input logic [1:0]           op,
   input logic                 out_valid,
   input logic [VEC_BYTES-1:0] pred,
   input logic [VEC_W-1:0]     out_vec
);
   function automatic logic [VEC_W-1:0] widen(input logic [VEC_BYTES-1:0] m);
      logic [VEC_W-1:0] r;
      for (int i = 0; i < VEC_BYTES; i++) r[8*i +: 8] = {8{m[i]}};
      return r;
   endfunction

   function automatic logic groups_ok(input logic [VEC_BYTES-1:0] m);
      logic ok;
      ok = 1'b1;
      for (int k = 0; k < VEC_BYTES / 4; k++)
         if (m[4*k +: 4] != 4'h0 && m[4*k +: 4] != 4'hF) ok = 1'b0;
      return ok;
   endfunction

   // R9: valid latency of one cycle
   p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(pred) && $stable(out_vec)));
   // R8: set lanes read 0xFF, clear lanes keep their prior byte
   p_fill_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_vec & widen(pred)) == widen(pred)));
   p_fill_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (((out_vec ^ $past(out_vec)) & ~widen(pred)) == '0));
   // R7: unsupported opcode yields zero
   p_bad_op_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'd3) |=> (pred == '0));
   // R3: word mode predicates come in whole groups of four
   p_word_groups_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cmp_word) |=> groups_ok(pred));
endmodule

bind vpred_unit vpred_unit_chk #(.VEC_BYTES(VEC_BYTES)) i_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cmp_word(cmp_word),
   .op(op), .out_valid(out_valid), .pred(pred), .out_vec(out_vec));

// File: tb/test_vpred_unit.sv
`timescale 1ns/1ps
module test_vpred_unit;
   localparam int VB = 128;
   localparam int VW = VB * 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [VW-1:0] vec_a = '0, vec_b = '0;
   logic [31:0]   scalar = '0;
   logic          cmp_word = 1'b0;
   logic [1:0]    op = '0;
   logic          inv_b = 1'b0;
   logic          out_valid;
   logic [VB-1:0] pred;
   logic [VW-1:0] out_vec;

   int total = 0;
   int bad = 0;
   logic [VW-1:0] exp_vec = '0;
   logic [VW-1:0] pat_a, pat_b, pat_wa, pat_wb;

   always #2.5 clk = ~clk;

   vpred_unit #(.VEC_BYTES(VB)) i_vpred_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vec_a(vec_a),
      .vec_b(vec_b), .scalar(scalar), .cmp_word(cmp_word), .op(op),
      .inv_b(inv_b), .out_valid(out_valid), .pred(pred), .out_vec(out_vec));

   function automatic logic [VB-1:0] m_cmp(input logic [VW-1:0] v,
                                           input logic [31:0] s, input logic w);
      logic [VB-1:0] r;
      for (int i = 0; i < VB; i++) begin
         if (w) r[i] = (v[32*(i/4) +: 32] == s);
         else   r[i] = ($signed(v[8*i +: 8]) > $signed(s[7:0]));
      end
      return r;
   endfunction

   function automatic logic [VB-1:0] m_comb(input logic [VB-1:0] a, b,
                                            input logic [1:0] o, input logic n);
      case (o)
         2'd0: return a & (n ? ~b : b);
         2'd1: return a | (n ? ~b : b);
         2'd2: return a ^ b;
         default: return '0;
      endcase
   endfunction

   task automatic chk_bit(input string tag, input logic act, exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic chk_pred(input string tag, input logic [VB-1:0] act, exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_vec(input string tag, input logic [VW-1:0] act, exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive one operation, check the registered result and the idle hold.
   task automatic run_op(input string tag, input logic [VW-1:0] a, b,
                         input logic [31:0] s, input logic w,
                         input logic [1:0] o, input logic n,
                         output logic [VB-1:0] got);
      logic [VB-1:0] ep;
      ep = m_comb(m_cmp(a, s, w), m_cmp(b, s, w), o, n);
      for (int i = 0; i < VB; i++) if (ep[i]) exp_vec[8*i +: 8] = 8'hFF;
      @(negedge clk);
      vec_a = a; vec_b = b; scalar = s; cmp_word = w; op = o; inv_b = n;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      got = pred;
      chk_bit({tag, " R9 out_valid"}, out_valid, 1'b1);
      chk_pred({tag, " pred"}, pred, ep);
      chk_vec({tag, " R8 out_vec"}, out_vec, exp_vec);
      vec_a = ~a; vec_b = ~b; op = 2'd1;
      @(negedge clk);
      chk_bit({tag, " R9 idle valid"}, out_valid, 1'b0);
      chk_pred({tag, " R9 hold pred"}, pred, ep);
      chk_vec({tag, " R9 hold vec"}, out_vec, exp_vec);
   endtask

   task automatic t_reset;
      chk_bit("R1 out_valid", out_valid, 1'b0);
      chk_pred("R1 pred", pred, '0);
      chk_vec("R1 out_vec", out_vec, '0);
   endtask

   task automatic t_byte_ops;
      logic [VB-1:0] g;
      run_op("R2 R4 and", pat_a, pat_b, 32'd31, 1'b0, 2'd0, 1'b0, g);
      run_op("R2 R4 or", pat_a, pat_b, 32'h0000_00F0, 1'b0, 2'd1, 1'b0, g);
      run_op("R2 R4 xor", pat_a, pat_b, 32'd5, 1'b0, 2'd2, 1'b0, g);
   endtask

   task automatic t_invert;
      logic [VB-1:0] g0, g1;
      run_op("R5 and-not", pat_a, pat_b, 32'd31, 1'b0, 2'd0, 1'b1, g0);
      run_op("R5 or-not", pat_b, pat_a, 32'd64, 1'b0, 2'd1, 1'b1, g0);
      run_op("R6 xor plain", pat_a, pat_b, 32'd100, 1'b0, 2'd2, 1'b0, g0);
      run_op("R6 xor inv", pat_a, pat_b, 32'd100, 1'b0, 2'd2, 1'b1, g1);
      chk_pred("R6 xor inv equals plain", g1, g0);
   endtask

   task automatic t_limits;
      logic [VB-1:0] g;
      run_op("R2 thr 127 or", pat_a, pat_b, 32'h7F, 1'b0, 2'd1, 1'b0, g);
      chk_pred("R2 none above 127", g, '0);
      run_op("R2 thr -128 and", pat_a, pat_a, 32'h80, 1'b0, 2'd0, 1'b0, g);
   endtask

   task automatic t_bad_op;
      logic [VB-1:0] g;
      run_op("R7 op3", pat_a, pat_b, 32'h80, 1'b0, 2'd3, 1'b0, g);
      chk_pred("R7 op3 zero", g, '0);
   endtask

   task automatic t_word;
      logic [VB-1:0] g;
      run_op("R3 word and", pat_wa, pat_wb, 32'd0, 1'b1, 2'd0, 1'b0, g);
      run_op("R3 word or-not", pat_wa, pat_wb, 32'd0, 1'b1, 2'd1, 1'b1, g);
      run_op("R3 word eq value", pat_wa, pat_wb, 32'h1234_5678, 1'b1, 2'd2, 1'b0, g);
   endtask

   initial begin
      for (int i = 0; i < VB; i++) begin
         pat_a[8*i +: 8] = 8'(i * 3);
         pat_b[8*i +: 8] = 8'(17 + i * 5);
      end
      for (int k = 0; k < VB / 4; k++) begin
         pat_wa[32*k +: 32] = (k % 3 == 0) ? 32'd0 : 32'(k * 32'h0101_0001);
         pat_wb[32*k +: 32] = (k % 2 == 0) ? 32'd0 :
                              (k % 5 == 1) ? 32'h1234_5678 : 32'(k + 7);
      end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_byte_ops();
      t_invert();
      t_limits();
      t_bad_op();
      t_word();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100000;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule